// File: doc/BRIEF.md
# Non-Pipelined Local Bus Cycle Sequencer

This block is the bus-master side of a 32-bit local bus. An internal requester presents one transfer at a time. Each transfer carries a direction (read or write), a space (memory or I/O), a kind (data or control), a byte address, a byte count and right-justified write data. The sequencer turns each accepted transfer into one non-pipelined bus cycle. On the bus it drives a doubleword address, four active-low byte enables, three cycle-definition lines and an active-low address strobe. It then waits for the slave's active-low ready and returns read bytes right-justified together with a completion pulse.

The controller has three named states. `ST_IDLE` is the bus idle state. `ST_T1` is the address state, the only state in which the strobe is low. `ST_T2` is the data state, which repeats as a wait state while ready is high. The transitions are:
- IDLE→T1 when a legal request is taken.
- T1→T2 always.
- T2→T2 while ready is high.
- T2→T1 when ready is low and a legal request is waiting (back-to-back, no idle state).
- T2→IDLE when ready is low and nothing legal is waiting.

A request whose bytes do not fit inside one aligned doubleword, or whose byte count is not 1, 2 or 4, is consumed with an error pulse and never reaches the bus.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst_n` is sampled low, the sequencer goes to idle. In idle the strobe is high, all byte enables are high (inactive), the write-data enable is low, and `rsp_done` and `req_err` are low.
- R2: Every cycle is exactly one T1 followed by at least one T2. `bus_strobe_n` is low for exactly one clock, the T1 clock, and is high in every T2.
- R3: T2 repeats while `bus_ready_n` is sampled high. The cycle ends on the first T2 edge with `bus_ready_n` low, and `rsp_done` is high for the single following clock. `bus_ready_n` is ignored during T1.
- R4: If a legal request is presented while the final T2 ends, the next clock is the new cycle's T1 with no idle clock. Otherwise the sequencer returns to idle with strobe and byte enables high.
- R5: `bus_be_n[n]` low means lane n (data bits 8n+7..8n) is used. For a byte count s (1, 2 or 4) and address bits 1:0 equal to o, lanes o through o+s-1 are low and the others are high.
- R6: A request with a byte count other than 1, 2 or 4, or with o+s greater than 4, is accepted but not run. `req_err` is high for one clock, and the strobe stays high.
- R7: `bus_addr` carries request address bits 31:2. The encodings are `bus_mio`=1 for memory and 0 for I/O, `bus_dat_ctl`=1 for data and 0 for control, and `bus_wr`=1 for write and 0 for read. All of them, plus the byte enables, are valid from T1 and unchanged through every T2 of that cycle.
- R8: In an I/O cycle, address bits 31:16 (bus_addr bits 31:16) are driven zero.
- R9: `bus_doe` is high only in T2 clocks of a write cycle. On each enabled lane, `bus_dout` carries the request byte (byte k of `req_wdata` is placed on lane o+k).
- R10: At the end of a read, only enabled lanes of `bus_din` are captured. They are shifted down by o lanes, and the upper bytes are filled with zero. The result is presented on `rsp_rdata` while `rsp_done` is high.
- R11: `req_accept` is high exactly in idle and in a T2 where `bus_ready_n` is low. It is low in T1 and in wait-state T2 clocks. A request is taken on a clock edge where both `req_valid` and `req_accept` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_data | input | 1 | 1 = data, 0 = control |
| req_addr | input | 32 | Byte address |
| req_size | input | 3 | Byte count (1, 2 or 4 legal) |
| req_wdata | input | 32 | Right-justified write data |
| req_accept | output | 1 | Sequencer can take a request this clock |
| req_err | output | 1 | One-clock pulse: request rejected |
| rsp_done | output | 1 | One-clock pulse: cycle finished |
| rsp_rdata | output | 32 | Right-justified read data |
| bus_addr | output | 30 | Doubleword address (bits 31:2) |
| bus_be_n | output | 4 | Byte-lane enables, active low |
| bus_mio | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_dat_ctl | output | 1 | 1 = data cycle, 0 = control cycle |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_strobe_n | output | 1 | Address strobe, active low in T1 |
| bus_ready_n | input | 1 | Slave ready, active low |
| bus_dout | output | 32 | Write data toward the bus |
| bus_doe | output | 1 | Write data driver enable |
| bus_din | input | 32 | Read data from the bus |

## Verification
The assertions check these properties on every clock:
- T1 is always followed by T2, and a one-clock strobe.
- A wait state follows whenever ready is high in T2, and a done pulse follows the ready clock.
- Address, enables and definition lines stay put through T2.
- I/O cycles keep the upper address zero, and the enables form a 1-, 2- or 4-lane group.
- The write driver is on only in write T2 clocks, and acceptance is never offered in T1.

Only the bench's scenarios can show the values themselves:
- that the enables and the I/O address mask match the request;
- that write bytes land on the right lanes, and read bytes come back right-justified with disabled lanes dropped;
- that illegal requests are rejected rather than run;
- that a request offered in the final T2 starts its T1 on the very next clock.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_T1   = 2'b01,
        ST_T2   = 2'b10
    } bus_st_e;

endpackage

// File: rtl/bcs_be_gen.sv
module bcs_be_gen #(
    parameter int DATA_W = 32,
    parameter int SZ_W   = 3,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [SZ_W-1:0]   size,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic              legal,
    output logic [DATA_W-1:0] wlanes
);

    logic [SZ_W:0] span;
    logic          pow2;
    logic          fits_bus;
    logic          in_dword;

    // one past the highest lane touched
    assign span     = {{(SZ_W+1-OFF_W){1'b0}}, off} + {1'b0, size};
    assign pow2     = (size != '0) && ((size & (size - 1'b1)) == '0);
    assign fits_bus = size <= SZ_W'(LANES);
    assign in_dword = span <= (SZ_W+1)'(LANES);
    assign legal    = pow2 && fits_bus && in_dword;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = legal && (OFF_W'(g) >= off) && ((SZ_W+1)'(g) < span);
    end

    // byte k of the request lands on lane off+k
    assign wlanes = wdata << {off, 3'b000};

endmodule

// File: rtl/bcs_rd_align.sv
module bcs_rd_align #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANES-1:0]  be,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] rj
);

    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign masked[g*8 +: 8] = be[g] ? rdata[g*8 +: 8] : 8'h00;
    end

    assign rj = masked >> {off, 3'b000};

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    req_legal,
    input  logic    rdy_n,
    output bus_st_e st,
    output logic    accept,
    output logic    take,
    output logic    reject,
    output logic    last_t2
);

    bus_st_e st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        last_t2 = (st == ST_T2) && !rdy_n;
        accept  = (st == ST_IDLE) || last_t2;
        take    = accept && req_valid && req_legal;
        reject  = accept && req_valid && !req_legal;
        st_nx   = st;
        unique case (st)
            ST_IDLE: st_nx = take ? ST_T1 : ST_IDLE;
            ST_T1:   st_nx = ST_T2;
            ST_T2: begin
                if (rdy_n) begin
                    st_nx = ST_T2;
                end else begin
                    st_nx = take ? ST_T1 : ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int IO_ADDR_W = 16,
    parameter int SZ_W      = 3,
    localparam int LANES    = DATA_W / 8,
    localparam int OFF_W    = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_io,
    input  logic                    req_data,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [SZ_W-1:0]         req_size,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_accept,
    output logic                    req_err,
    output logic                    rsp_done,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [ADDR_W-1:OFF_W]   bus_addr,
    output logic [LANES-1:0]        bus_be_n,
    output logic                    bus_mio,
    output logic                    bus_dat_ctl,
    output logic                    bus_wr,
    output logic                    bus_strobe_n,
    input  logic                    bus_ready_n,
    output logic [DATA_W-1:0]       bus_dout,
    output logic                    bus_doe,
    input  logic [DATA_W-1:0]       bus_din
);

    bus_st_e st_q;
    logic    take;
    logic    reject;
    logic    last_t2;
    logic    req_legal;

    logic [LANES-1:0]  req_be;
    logic [DATA_W-1:0] req_wlanes;
    logic [ADDR_W-1:0] addr_eff;
    logic [DATA_W-1:0] rd_rj;

    // latched cycle fields
    logic [ADDR_W-1:OFF_W] cyc_addr;
    logic [LANES-1:0]      cyc_be;
    logic [OFF_W-1:0]      cyc_off;
    logic                  cyc_mem;
    logic                  cyc_dat;
    logic                  cyc_wr;
    logic [DATA_W-1:0]     cyc_wdata;

    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_legal (req_legal),
        .rdy_n     (bus_ready_n),
        .st        (st_q),
        .accept    (req_accept),
        .take      (take),
        .reject    (reject),
        .last_t2   (last_t2)
    );

    bcs_be_gen #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_be (
        .off    (req_addr[OFF_W-1:0]),
        .size   (req_size),
        .wdata  (req_wdata),
        .be     (req_be),
        .legal  (req_legal),
        .wlanes (req_wlanes)
    );

    bcs_rd_align #(.DATA_W(DATA_W)) u_rd (
        .rdata (bus_din),
        .be    (cyc_be),
        .off   (cyc_off),
        .rj    (rd_rj)
    );

    // I/O space is narrower than memory space: clear the upper bits
    always_comb begin
        addr_eff = req_addr;
        if (req_io) begin
            addr_eff[ADDR_W-1:IO_ADDR_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_addr  <= '0;
            cyc_be    <= '0;
            cyc_off   <= '0;
            cyc_mem   <= 1'b1;
            cyc_dat   <= 1'b1;
            cyc_wr    <= 1'b0;
            cyc_wdata <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done_q <= last_t2;
            err_q  <= reject;
            if (last_t2 && !cyc_wr) begin
                rdata_q <= rd_rj;
            end
            if (take) begin
                cyc_addr  <= addr_eff[ADDR_W-1:OFF_W];
                cyc_be    <= req_be;
                cyc_off   <= req_addr[OFF_W-1:0];
                cyc_mem   <= !req_io;
                cyc_dat   <= req_data;
                cyc_wr    <= req_write;
                cyc_wdata <= req_wlanes;
            end
        end
    end

    // output decode
    always_comb begin
        bus_addr     = cyc_addr;
        bus_mio      = cyc_mem;
        bus_dat_ctl  = cyc_dat;
        bus_wr       = cyc_wr;
        bus_dout     = cyc_wdata;
        bus_strobe_n = 1'b1;
        bus_be_n     = '1;
        bus_doe      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                bus_strobe_n = 1'b1;
            end
            ST_T1: begin
                bus_strobe_n = 1'b0;
                bus_be_n     = ~cyc_be;
            end
            ST_T2: begin
                bus_be_n = ~cyc_be;
                bus_doe  = cyc_wr;
            end
            default: begin
                bus_strobe_n = 1'b1;
            end
        endcase
        rsp_done  = done_q;
        req_err   = err_q;
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LANES     = 4,
    parameter int IO_ADDR_W = 16,
    localparam int OFF_W    = $clog2(LANES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input bus_st_e               st,
    input logic                  strobe_n,
    input logic [LANES-1:0]      be_n,
    input logic [ADDR_W-1:OFF_W] addr,
    input logic                  mio,
    input logic                  dat_ctl,
    input logic                  wr,
    input logic                  doe,
    input logic                  rdy_n,
    input logic                  done,
    input logic                  accept
);

    // R2: address state is always followed by a data state
    p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_T1 |=> st == ST_T2);

    // R2: the strobe lasts exactly one clock
    p_strobe_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> strobe_n);

    // R3: ready high in T2 inserts a wait state
    p_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_T2 && rdy_n) |=> st == ST_T2);

    // R3: done follows the ready clock
    p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_T2 && !rdy_n) |=> done);

    // R5: the enabled lanes form a 1, 2 or 4 lane group
    p_be_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (be_n != '1) |-> ($countones(~be_n) == 1 || $countones(~be_n) == 2
                          || $countones(~be_n) == 4));

    // R7: cycle fields hold through every data state
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_T2 |-> ($stable(addr) && $stable(be_n) && $stable(mio)
                         && $stable(dat_ctl) && $stable(wr)));

    // R8: I/O cycles keep the upper address zero
    p_io_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (be_n != '1 && !mio) |-> addr[ADDR_W-1:IO_ADDR_W] == '0);

    // R9: write driver only during write data states
    p_doe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> (wr && st == ST_T2));

    // R11: no acceptance during the address state
    p_no_accept_t1_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_T1 |-> !accept);

endmodule

bind bus_cycle_seq bcs_checker #(
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .IO_ADDR_W (IO_ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st_q),
    .strobe_n (bus_strobe_n),
    .be_n     (bus_be_n),
    .addr     (bus_addr),
    .mio      (bus_mio),
    .dat_ctl  (bus_dat_ctl),
    .wr       (bus_wr),
    .doe      (bus_doe),
    .rdy_n    (bus_ready_n),
    .done     (rsp_done),
    .accept   (req_accept)
);

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;

    localparam int CLK_P = 10;
    localparam int WD_CYC = 150000;

    typedef struct {
        logic        wr;
        logic        io;
        logic        dc;
        logic [31:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_data = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_accept;
    logic        req_err;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [31:2] bus_addr;
    logic [3:0]  bus_be_n;
    logic        bus_mio;
    logic        bus_dat_ctl;
    logic        bus_wr;
    logic        bus_strobe_n;
    logic        bus_ready_n = 1'b1;
    logic [31:0] bus_dout;
    logic        bus_doe;
    logic [31:0] bus_din = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    bus_cycle_seq dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] off, input logic [2:0] sz);
        if (sz == 3'd1) return 4'b0001 << off;
        if (sz == 3'd2 && off != 2'd3) return 4'b0011 << off;
        if (sz == 3'd4 && off == 2'd0) return 4'b1111;
        return 4'b0000;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic logic [29:0] exp_addr(input txn_t t);
        logic [31:0] a;
        a = t.io ? (t.addr & 32'h0000_FFFF) : t.addr;
        return a[31:2];
    endfunction

    function automatic txn_t gen(input bit legal_only);
        txn_t t;
        logic [1:0] off;
        t.wr = 1'($urandom % 2);
        t.io = 1'($urandom % 2);
        t.dc = 1'($urandom % 2);
        t.wdata = $urandom;
        if (legal_only || ($urandom % 8) < 6) begin
            case ($urandom % 3)
                0: t.size = 3'd1;
                1: t.size = 3'd2;
                default: t.size = 3'd4;
            endcase
            off = 2'($urandom % (5 - int'(t.size)));
        end else begin
            t.size = 3'($urandom % 8);
            off = 2'($urandom % 4);
        end
        t.addr = {$urandom, 2'b00};
        t.addr[1:0] = off;
        return t;
    endfunction

    task automatic drive_req(input txn_t t);
        req_valid = 1'b1;
        req_write = t.wr;
        req_io    = t.io;
        req_data  = t.dc;
        req_addr  = t.addr;
        req_size  = t.size;
        req_wdata = t.wdata;
    endtask

    // present from idle; returns at the negedge after the taking edge
    task automatic issue(input txn_t t, output bit legal);
        @(negedge clk);
        drive_req(t);
        #1;
        chk(req_accept == 1'b1, "R11 accept in idle", 32'(req_accept), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        legal = exp_be(t.addr[1:0], t.size) != 4'b0;
        if (!legal) begin
            chk(req_err == 1'b1, "R6 err pulse", 32'(req_err), 1);
            chk(bus_strobe_n == 1'b1, "R6 no cycle started", 32'(bus_strobe_n), 1);
        end else begin
            chk(req_err == 1'b0, "R6 no err on legal", 32'(req_err), 0);
        end
    endtask

    // entered at the negedge inside T1
    task automatic run_cycle(input txn_t t, input int waits, input bit chain,
                             input txn_t nxt);
        logic [3:0]  be;
        logic [31:0] m;
        logic [31:0] rd_exp;
        logic [29:0] ea;
        be = exp_be(t.addr[1:0], t.size);
        m  = lane_mask(be);
        ea = exp_addr(t);
        rd_exp = '0;
        chk(bus_strobe_n == 1'b0, "R2 strobe low in T1", 32'(bus_strobe_n), 0);
        chk(bus_addr == ea, t.io ? "R8 io address" : "R7 address", 32'(bus_addr), 32'(ea));
        chk(bus_be_n == ~be, "R5 byte enables", 32'(bus_be_n), 32'(~be));
        chk({bus_mio, bus_dat_ctl, bus_wr} == {~t.io, t.dc, t.wr}, "R7 definition",
            32'({bus_mio, bus_dat_ctl, bus_wr}), 32'({~t.io, t.dc, t.wr}));
        chk(bus_doe == 1'b0, "R9 no drive in T1", 32'(bus_doe), 0);
        chk(req_accept == 1'b0, "R11 no accept in T1", 32'(req_accept), 0);
        bus_ready_n = 1'($urandom % 2); // ignored in T1 (R3)
        @(posedge clk);
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            chk(bus_strobe_n == 1'b1, "R2 strobe high in T2", 32'(bus_strobe_n), 1);
            chk(bus_addr == ea && bus_be_n == ~be, "R7 hold in T2",
                32'(bus_be_n), 32'(~be));
            chk(bus_doe == t.wr, "R9 driver enable", 32'(bus_doe), 32'(t.wr));
            chk(rsp_done == 1'b0, "R3 no early done", 32'(rsp_done), 0);
            if (t.wr) begin
                chk((bus_dout & m) == ((t.wdata << (8 * t.addr[1:0])) & m),
                    "R9 write lanes", bus_dout & m, (t.wdata << (8 * t.addr[1:0])) & m);
            end
            if (i == waits) begin
                bus_ready_n = 1'b0;
                bus_din = $urandom;
                rd_exp = (bus_din & m) >> (8 * t.addr[1:0]);
                if (chain) drive_req(nxt);
            end else begin
                bus_ready_n = 1'b1;
            end
            #1;
            chk(req_accept == (i == waits), "R11 accept only at end",
                32'(req_accept), 32'(i == waits));
            @(posedge clk);
        end
        @(negedge clk);
        bus_ready_n = 1'b1;
        req_valid = 1'b0;
        chk(rsp_done == 1'b1, "R3 done after ready", 32'(rsp_done), 1);
        if (!t.wr) begin
            chk(rsp_rdata == rd_exp, "R10 read data", rsp_rdata, rd_exp);
        end
        if (chain) begin
            chk(bus_strobe_n == 1'b0, "R4 back-to-back T1", 32'(bus_strobe_n), 0);
        end else begin
            chk(bus_strobe_n == 1'b1 && bus_be_n == 4'hF, "R4 return to idle",
                32'(bus_be_n), 32'hF);
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        txn_t cur;
        txn_t nxt;
        bit   legal;
        bit   chained;
        bit   chain;
        void'($urandom(32'd7021));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bus_strobe_n == 1'b1, "R1 strobe", 32'(bus_strobe_n), 1);
        chk(bus_be_n == 4'hF, "R1 byte enables", 32'(bus_be_n), 32'hF);
        chk(bus_doe == 1'b0 && rsp_done == 1'b0 && req_err == 1'b0, "R1 flags",
            32'({bus_doe, rsp_done, req_err}), 0);
        rst_n = 1'b1;

        // directed: illegal shapes (R6)
        cur = '{wr: 1'b0, io: 1'b0, dc: 1'b1, addr: 32'h1000_0002, size: 3'd4, wdata: 32'h0};
        issue(cur, legal);
        cur.addr = 32'h1000_0003; cur.size = 3'd2;
        issue(cur, legal);
        cur.addr = 32'h1000_0000; cur.size = 3'd3;
        issue(cur, legal);

        // directed: word at offset 1 is legal (R5), long wait (R3)
        cur = '{wr: 1'b1, io: 1'b0, dc: 1'b1, addr: 32'hABCD_1231, size: 3'd2,
                wdata: 32'h0000_BEEF};
        issue(cur, legal);
        nxt = cur;
        run_cycle(cur, 5, 1'b0, nxt);

        // directed: I/O read with high address bits set (R8), chained into a write (R4)
        cur = '{wr: 1'b0, io: 1'b1, dc: 1'b1, addr: 32'hFFFF_8402, size: 3'd1,
                wdata: 32'h0};
        nxt = '{wr: 1'b1, io: 1'b0, dc: 1'b0, addr: 32'h0000_0040, size: 3'd4,
                wdata: 32'h1234_5678};
        issue(cur, legal);
        run_cycle(cur, 0, 1'b1, nxt);
        run_cycle(nxt, 2, 1'b0, nxt);

        // constrained random
        chained = 1'b0;
        for (int k = 0; k < 120; k++) begin
            if (!chained) begin
                cur = gen(1'b0);
                issue(cur, legal);
                if (!legal) continue;
            end else begin
                cur = nxt;
            end
            chain = (k < 119) && (($urandom % 3) == 0);
            nxt = gen(1'b1);
            run_cycle(cur, int'($urandom % 4), chain, nxt);
            chained = chain;
        end

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule